// File: doc/BRIEF.md
# Conditional Register Poll-Wait Engine

This block carries out one wait-on-value command for a command processor. It takes a command that has already been decoded. The command holds a comparison function, a target (register or memory space, plus an address), a reference value, a mask, a delay between polls and a retry budget. The block then reads the target through a simple request/response port. Each read value is masked and compared with the masked reference.

While a command is in flight the block holds `busy` high. It also raises one of two stall outputs, so the front-end stage named by the command stays stalled. If a compare fails and retries remain, the block waits a set number of idle cycles after the response and then reads again. The command ends with a one-cycle `done` pulse when a compare passes. It ends with a one-cycle `timeout` pulse when the budget runs out. In both cases the last value read stays on `last_data`.

The "always" function still makes one real read and waits for its response before it reports done. That read adds latency behind an earlier write to the same location, which may not have landed yet.

Top module: `regwait_engine`

## Requirements
- R1: After reset, `busy`, `rd_req`, `done`, `timeout`, both stall outputs and `last_data` are all zero, and `cmd_ready` is one.
- R2: `cmd_func` selects the pass condition on unsigned values: 0 always, 1 less-than, 2 less-or-equal, 3 equal, 4 not-equal, 5 greater-or-equal, 6 greater-than. Each condition is read value (left) against reference (right). Code 7 never passes, so the command always ends in timeout.
- R3: The compare uses `rd_resp_data & cmd_mask` against `cmd_ref & cmd_mask`, so bits outside the mask have no effect on the outcome.
- R4: With function 0, exactly one read is issued. `done` rises in the cycle after the response is accepted, and never earlier.
- R5: Each read is a one-cycle `rd_req` pulse. `rd_addr` equals the command address and `rd_space` equals the command space bit (0 register, 1 memory). No second request is raised before the response to the first arrives.
- R6: After a failing response, the block waits `cmd_interval`+1 cycles before the next `rd_req`. With response latency L, counted from the request cycle to the response cycle, consecutive requests are L+2+`cmd_interval` cycles apart.
- R7: A command issues at most 1+`cmd_retries` reads. If all of them fail, `timeout` pulses for one cycle, the block returns to idle, and `last_data` holds the final read value.
- R8: `busy` is high from the cycle after acceptance until the end pulse. `cmd_ready` is the inverse of `busy`, and a `cmd_valid` while busy is ignored.
- R9: While busy, `stall_main` is high when the engine bit was 0 and `stall_prefetch` is high when it was 1. Neither stall output is high while idle.
- R10: `done` and `timeout` are single-cycle pulses, never both high at once. `last_data` is updated on every accepted response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_func | input | 3 | Compare function code |
| cmd_space | input | 1 | Target space, 0 register, 1 memory |
| cmd_engine | input | 1 | Stage to stall, 0 main, 1 prefetch |
| cmd_addr | input | ADDR_W | Target address |
| cmd_ref | input | DATA_W | Reference value |
| cmd_mask | input | DATA_W | Compare mask |
| cmd_interval | input | IVL_W | Idle cycles between polls, minus one |
| cmd_retries | input | RETRY_W | Re-reads allowed after the first read |
| rd_req | output | 1 | Read request pulse |
| rd_space | output | 1 | Space of the read |
| rd_addr | output | ADDR_W | Address of the read |
| rd_resp_valid | input | 1 | Read response present |
| rd_resp_data | input | DATA_W | Read response value |
| busy | output | 1 | Command in flight |
| stall_main | output | 1 | Stall the main engine |
| stall_prefetch | output | 1 | Stall the prefetch parser |
| done | output | 1 | Compare passed, one-cycle pulse |
| timeout | output | 1 | Retries exhausted, one-cycle pulse |
| last_data | output | DATA_W | Most recent read value |

## Verification
The hardest case to reach from the ports is how the poll delay interacts with the response latency. The delay must begin only after the response, so a bench that always answers with the same latency could not tell that apart from a delay that starts at the request. The stimulus uses a responder whose latency is set per command. It sweeps several latencies and intervals against commands that are made to fail, and checks the exact spacing between requests. A second hard case is a command offered while the block is busy. The bench offers a command that would end differently if it were taken, then checks the read count and the kind of end pulse of the command that was already running.

// File: rtl/regwait_pkg.sv
package regwait_pkg;

  typedef enum logic [2:0] {
    CMP_ALWAYS = 3'd0,
    CMP_LT     = 3'd1,
    CMP_LE     = 3'd2,
    CMP_EQ     = 3'd3,
    CMP_NE     = 3'd4,
    CMP_GE     = 3'd5,
    CMP_GT     = 3'd6,
    CMP_NEVER  = 3'd7
  } cmp_fn_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DELAY = 2'd3
  } poll_st_e;

endpackage

// File: rtl/regwait_compare.sv
module regwait_compare
  import regwait_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  cmp_fn_e             fn,
  input  logic [DATA_W-1:0]   rd_val,
  input  logic [DATA_W-1:0]   ref_val,
  input  logic [DATA_W-1:0]   mask,
  output logic                pass
);

  logic [DATA_W-1:0] lhs;
  logic [DATA_W-1:0] rhs;

  always_comb begin
    lhs = rd_val & mask;
    rhs = ref_val & mask;
    unique case (fn)
      CMP_ALWAYS: pass = 1'b1;
      CMP_LT:     pass = (lhs <  rhs);
      CMP_LE:     pass = (lhs <= rhs);
      CMP_EQ:     pass = (lhs == rhs);
      CMP_NE:     pass = (lhs != rhs);
      CMP_GE:     pass = (lhs >= rhs);
      CMP_GT:     pass = (lhs >  rhs);
      default:    pass = 1'b0;
    endcase
  end

endmodule

// File: rtl/regwait_timer.sv
module regwait_timer #(
  parameter int IVL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IVL_W-1:0] load_val,
  input  logic             tick,
  output logic             expired
);

  logic [IVL_W-1:0] cnt_q;
  logic [IVL_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load) begin
      cnt_d  = load_val;
      cnt_en = 1'b1;
    end else if (tick && (cnt_q != '0)) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

  // R6: a running count only moves down by one per tick
  p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/regwait_fsm.sv
module regwait_fsm
  import regwait_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32,
  parameter int IVL_W   = 16,
  parameter int RETRY_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [2:0]         cmd_func,
  input  logic               cmd_space,
  input  logic               cmd_engine,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [DATA_W-1:0]  cmd_ref,
  input  logic [DATA_W-1:0]  cmd_mask,
  input  logic [IVL_W-1:0]   cmd_interval,
  input  logic [RETRY_W-1:0] cmd_retries,
  input  logic               rd_resp_valid,
  input  logic [DATA_W-1:0]  rd_resp_data,
  input  logic               cmp_pass,
  input  logic               tmr_expired,
  output logic               tmr_load,
  output logic               tmr_tick,
  output logic [IVL_W-1:0]   tmr_val,
  output cmp_fn_e            fn_q,
  output logic [DATA_W-1:0]  ref_q,
  output logic [DATA_W-1:0]  mask_q,
  output logic               space_q,
  output logic               engine_q,
  output logic [ADDR_W-1:0]  addr_q,
  output logic               rd_req,
  output logic               busy,
  output logic               done,
  output logic               timeout,
  output logic [DATA_W-1:0]  last_data
);

  poll_st_e           st_q, st_d;
  logic [RETRY_W-1:0] retry_q, retry_d;
  logic [IVL_W-1:0]   ivl_q;
  logic               cmd_en;
  logic               retry_en;
  logic               data_en;
  logic               done_d, timeout_d;

  always_comb begin
    st_d      = st_q;
    retry_d   = retry_q;
    cmd_en    = 1'b0;
    retry_en  = 1'b0;
    data_en   = 1'b0;
    done_d    = 1'b0;
    timeout_d = 1'b0;
    tmr_load  = 1'b0;
    tmr_tick  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          cmd_en   = 1'b1;
          retry_en = 1'b1;
          retry_d  = cmd_retries;
          st_d     = ST_ISSUE;
        end
      end
      ST_ISSUE: st_d = ST_WAIT;
      ST_WAIT: begin
        if (rd_resp_valid) begin
          data_en = 1'b1;
          if (cmp_pass) begin
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end else if (retry_q == '0) begin
            timeout_d = 1'b1;
            st_d      = ST_IDLE;
          end else begin
            retry_en = 1'b1;
            retry_d  = retry_q - 1'b1;
            tmr_load = 1'b1;
            st_d     = ST_DELAY;
          end
        end
      end
      ST_DELAY: begin
        tmr_tick = 1'b1;
        if (tmr_expired) st_d = ST_ISSUE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      done    <= 1'b0;
      timeout <= 1'b0;
    end else begin
      st_q    <= st_d;
      done    <= done_d;
      timeout <= timeout_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fn_q     <= CMP_ALWAYS;
      ref_q    <= '0;
      mask_q   <= '0;
      space_q  <= 1'b0;
      engine_q <= 1'b0;
      addr_q   <= '0;
      ivl_q    <= '0;
    end else if (cmd_en) begin
      fn_q     <= cmp_fn_e'(cmd_func);
      ref_q    <= cmd_ref;
      mask_q   <= cmd_mask;
      space_q  <= cmd_space;
      engine_q <= cmd_engine;
      addr_q   <= cmd_addr;
      ivl_q    <= cmd_interval;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      retry_q <= '0;
    end else if (retry_en) begin
      retry_q <= retry_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_data <= '0;
    end else if (data_en) begin
      last_data <= rd_resp_data;
    end
  end

  assign tmr_val = ivl_q;
  assign rd_req  = (st_q == ST_ISSUE);
  assign busy    = (st_q != ST_IDLE);

  // R5: a request lasts one cycle and the next waits for a response
  p_req_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  // R8: an offered command while idle makes the block busy
  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> busy);
  // R7: the end pulses coincide with an idle block
  p_end_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout) |-> !busy);
  // R7: timeout only once the budget was empty
  p_timeout_budget_r7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> ($past(retry_q) == '0));
  // R10: end pulses are exclusive and one cycle long
  p_excl_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2: code 7 never ends in done
  p_never_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fn_q == CMP_NEVER) |=> !done);

endmodule

// File: rtl/regwait_engine.sv
module regwait_engine
  import regwait_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32,
  parameter int IVL_W   = 16,
  parameter int RETRY_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [2:0]         cmd_func,
  input  logic               cmd_space,
  input  logic               cmd_engine,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [DATA_W-1:0]  cmd_ref,
  input  logic [DATA_W-1:0]  cmd_mask,
  input  logic [IVL_W-1:0]   cmd_interval,
  input  logic [RETRY_W-1:0] cmd_retries,
  output logic               rd_req,
  output logic               rd_space,
  output logic [ADDR_W-1:0]  rd_addr,
  input  logic               rd_resp_valid,
  input  logic [DATA_W-1:0]  rd_resp_data,
  output logic               busy,
  output logic               stall_main,
  output logic               stall_prefetch,
  output logic               done,
  output logic               timeout,
  output logic [DATA_W-1:0]  last_data
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[SYNC_STAGES-1];

  cmp_fn_e           fn_q;
  logic [DATA_W-1:0] ref_q, mask_q;
  logic              engine_q;
  logic              cmp_pass;
  logic              tmr_load, tmr_tick, tmr_expired;
  logic [IVL_W-1:0]  tmr_val;

  regwait_compare #(.DATA_W(DATA_W)) u_cmp (
    .fn      (fn_q),
    .rd_val  (rd_resp_data),
    .ref_val (ref_q),
    .mask    (mask_q),
    .pass    (cmp_pass)
  );

  regwait_timer #(.IVL_W(IVL_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .tick     (tmr_tick),
    .expired  (tmr_expired)
  );

  regwait_fsm #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IVL_W(IVL_W), .RETRY_W(RETRY_W)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .cmd_valid     (cmd_valid),
    .cmd_func      (cmd_func),
    .cmd_space     (cmd_space),
    .cmd_engine    (cmd_engine),
    .cmd_addr      (cmd_addr),
    .cmd_ref       (cmd_ref),
    .cmd_mask      (cmd_mask),
    .cmd_interval  (cmd_interval),
    .cmd_retries   (cmd_retries),
    .rd_resp_valid (rd_resp_valid),
    .rd_resp_data  (rd_resp_data),
    .cmp_pass      (cmp_pass),
    .tmr_expired   (tmr_expired),
    .tmr_load      (tmr_load),
    .tmr_tick      (tmr_tick),
    .tmr_val       (tmr_val),
    .fn_q          (fn_q),
    .ref_q         (ref_q),
    .mask_q        (mask_q),
    .space_q       (rd_space),
    .engine_q      (engine_q),
    .addr_q        (rd_addr),
    .rd_req        (rd_req),
    .busy          (busy),
    .done          (done),
    .timeout       (timeout),
    .last_data     (last_data)
  );

  assign cmd_ready      = !busy;
  assign stall_main     = busy && !engine_q;
  assign stall_prefetch = busy &&  engine_q;

  // R9: exactly one stage is stalled while busy, none while idle
  p_stall_onehot_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    busy |-> $onehot({stall_main, stall_prefetch}));
  p_idle_nostall_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !busy |-> !(stall_main || stall_prefetch));
  // R4: an always-mode end needs a response in the cycle before
  p_always_after_resp_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && fn_q == CMP_ALWAYS) |-> $past(rd_resp_valid));

endmodule

// File: tb/regwait_engine_bench.sv
`timescale 1ns/1ps
module regwait_engine_bench;

  localparam int DW = 32;
  localparam int AW = 32;
  localparam int IW = 16;
  localparam int RW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [2:0]    cmd_func = '0;
  logic          cmd_space = 1'b0;
  logic          cmd_engine = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_ref = '0;
  logic [DW-1:0] cmd_mask = '0;
  logic [IW-1:0] cmd_interval = '0;
  logic [RW-1:0] cmd_retries = '0;
  logic          rd_req;
  logic          rd_space;
  logic [AW-1:0] rd_addr;
  logic          rd_resp_valid = 1'b0;
  logic [DW-1:0] rd_resp_data = '0;
  logic          busy, stall_main, stall_prefetch, done, timeout;
  logic [DW-1:0] last_data;

  always #5 clk = ~clk;

  regwait_engine u_regwait_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_func(cmd_func), .cmd_space(cmd_space), .cmd_engine(cmd_engine),
    .cmd_addr(cmd_addr), .cmd_ref(cmd_ref), .cmd_mask(cmd_mask),
    .cmd_interval(cmd_interval), .cmd_retries(cmd_retries),
    .rd_req(rd_req), .rd_space(rd_space), .rd_addr(rd_addr),
    .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
    .busy(busy), .stall_main(stall_main), .stall_prefetch(stall_prefetch),
    .done(done), .timeout(timeout), .last_data(last_data)
  );

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // responder state
  int            rsp_lat = 1;
  logic [DW-1:0] rsp_vals [0:15];
  int            n_reads = 0;
  int            prev_req_cyc = 0;
  int            last_req_cyc = 0;
  int            last_resp_cyc = 0;
  logic [AW-1:0] seen_addr = '0;
  logic          seen_space = 1'b0;
  logic          got_done, got_to;
  int            end_cyc;

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_pass(input int fn, input logic [DW-1:0] d,
                                    input logic [DW-1:0] r, input logic [DW-1:0] m);
    logic [DW-1:0] a = d & m;
    logic [DW-1:0] b = r & m;
    case (fn)
      0: return 1'b1;
      1: return a < b;
      2: return a <= b;
      3: return a == b;
      4: return a != b;
      5: return a >= b;
      6: return a > b;
      default: return 1'b0;
    endcase
  endfunction

  initial begin : responder
    forever begin
      @(negedge clk);
      if (rd_req) begin
        prev_req_cyc = last_req_cyc;
        last_req_cyc = cyc;
        seen_addr    = rd_addr;
        seen_space   = rd_space;
        repeat (rsp_lat) @(negedge clk);
        rd_resp_valid = 1'b1;
        rd_resp_data  = rsp_vals[(n_reads > 15) ? 15 : n_reads];
        last_resp_cyc = cyc;
        n_reads++;
        @(negedge clk);
        rd_resp_valid = 1'b0;
      end
    end
  end

  task automatic start_cmd(input int fn, input logic [DW-1:0] r, input logic [DW-1:0] m,
                           input int ivl, input int rty, input logic eng,
                           input logic spc, input logic [AW-1:0] adr);
    @(negedge clk);
    n_reads      = 0;
    cmd_valid    = 1'b1;
    cmd_func     = fn[2:0];
    cmd_ref      = r;
    cmd_mask     = m;
    cmd_interval = ivl[IW-1:0];
    cmd_retries  = rty[RW-1:0];
    cmd_engine   = eng;
    cmd_space    = spc;
    cmd_addr     = adr;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_end();
    got_done = 1'b0;
    got_to   = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (done || timeout) begin
        got_done = done;
        got_to   = timeout;
        end_cyc  = cyc;
        return;
      end
      @(negedge clk);
    end
    chk(1'b0, "watchdog: command never ended", 0, 1);
  endtask

  task automatic fill_vals(input logic [DW-1:0] v);
    for (int i = 0; i < 16; i++) rsp_vals[i] = v;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : stim
    fill_vals('0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!busy && !rd_req && !done && !timeout, "R1 idle outputs", {busy, rd_req, done, timeout}, 0);
    chk(!stall_main && !stall_prefetch, "R1 stalls", {stall_main, stall_prefetch}, 0);
    chk(last_data == 0, "R1 last_data", last_data, 0);
    chk(cmd_ready == 1'b1, "R1 cmd_ready", cmd_ready, 1);

    // R2/R3 sweep: function x relation x mask
    for (int fn = 0; fn < 8; fn++) begin
      for (int rel = 0; rel < 3; rel++) begin
        for (int mk = 0; mk < 2; mk++) begin
          logic [DW-1:0] r, m, d;
          logic          p;
          r = 32'h0000_0100;
          m = mk ? 32'h0000_0FF0 : 32'hFFFF_FFFF;
          d = r - 32'h10 + 32'(rel) * 32'h10;
          if (mk) d = d | 32'hA000_0000;   // R3 noise outside the mask
          fill_vals(d);
          p = exp_pass(fn, d, r, m);
          rsp_lat = 1;
          start_cmd(fn, r, m, 1, 2, 1'b0, 1'b0, 32'h40);
          wait_end();
          chk(got_done == p && got_to == !p, $sformatf("R2/R3 outcome fn%0d rel%0d mk%0d", fn, rel, mk),
              {got_done, got_to}, {p, !p});
          chk(n_reads == (p ? 1 : 3), $sformatf("R7 reads fn%0d rel%0d mk%0d", fn, rel, mk),
              n_reads, p ? 1 : 3);
          chk(last_data == d, "R10 last_data", last_data, d);
        end
      end
    end

    // R4 always with long latency: done one cycle after the response
    fill_vals(32'h1234_5678);
    rsp_lat = 5;
    start_cmd(0, 32'hFFFF, 32'h0, 0, 3, 1'b0, 1'b0, 32'h88);
    wait_end();
    chk(got_done && !got_to, "R4 always ends in done", {got_done, got_to}, 2'b10);
    chk(n_reads == 1, "R4 one read", n_reads, 1);
    chk(end_cyc == last_resp_cyc + 1, "R4 done after response", end_cyc, last_resp_cyc + 1);
    @(negedge clk);
    chk(!done, "R10 done one cycle", done, 0);

    // R5 address/space, R6 spacing over latency and interval
    for (int li = 0; li < 3; li++) begin
      for (int ii = 0; ii < 3; ii++) begin
        int lat, ivl;
        lat = 1 + 2 * li;
        ivl = (ii == 0) ? 0 : ((ii == 1) ? 3 : 7);
        rsp_lat = lat;
        fill_vals(32'h55);
        start_cmd(4, 32'h55, 32'hFF, ivl, 1, 1'b1, 1'(ii & 1), 32'h1000 + 32'(ivl));
        wait_end();
        chk(got_to && n_reads == 2, $sformatf("R7 two reads lat%0d ivl%0d", lat, ivl), n_reads, 2);
        chk(last_req_cyc - prev_req_cyc == lat + 2 + ivl,
            $sformatf("R6 gap lat%0d ivl%0d", lat, ivl), last_req_cyc - prev_req_cyc, lat + 2 + ivl);
        chk(seen_addr == 32'h1000 + 32'(ivl) && seen_space == 1'(ii & 1), "R5 address and space",
            {seen_space, seen_addr}, {1'(ii & 1), 32'h1000 + 32'(ivl)});
      end
    end

    // R7 zero retries: a single read then timeout
    rsp_lat = 1;
    fill_vals(32'h3);
    start_cmd(3, 32'h4, 32'hF, 2, 0, 1'b0, 1'b0, 32'h0);
    wait_end();
    chk(got_to && n_reads == 1, "R7 zero retries", n_reads, 1);
    @(negedge clk);
    chk(!timeout, "R10 timeout one cycle", timeout, 0);

    // R7 changing values, budget runs out, last value kept
    for (int i = 0; i < 16; i++) rsp_vals[i] = 32'(i + 1);
    start_cmd(3, 32'd99, 32'hFFFF_FFFF, 1, 4, 1'b0, 1'b0, 32'h0);
    wait_end();
    chk(got_to && n_reads == 5, "R7 five reads then timeout", n_reads, 5);
    chk(last_data == 32'd5, "R7 last value", last_data, 5);

    // R2 pass on the third read
    rsp_vals[0] = 32'd7; rsp_vals[1] = 32'd7; rsp_vals[2] = 32'd9;
    start_cmd(3, 32'd9, 32'hFFFF_FFFF, 2, 5, 1'b0, 1'b0, 32'h0);
    wait_end();
    chk(got_done && n_reads == 3, "R2 pass on third read", n_reads, 3);

    // R2 unsigned compare across the top bit
    fill_vals(32'h8000_0000);
    start_cmd(6, 32'h1, 32'hFFFF_FFFF, 0, 0, 1'b0, 1'b0, 32'h0);
    wait_end();
    chk(got_done, "R2 unsigned greater-than", got_done, 1);

    // R8/R9 busy window, refusal and stall selection
    for (int eng = 0; eng < 2; eng++) begin
      fill_vals(32'h0);
      rsp_lat = 2;
      start_cmd(7, 32'h0, 32'h0, 20, 1, 1'(eng), 1'b0, 32'h0);
      chk(busy && !cmd_ready, "R8 busy after accept", {busy, cmd_ready}, 2'b10);
      chk(stall_main == !eng && stall_prefetch == 1'(eng), $sformatf("R9 stall eng%0d", eng),
          {stall_main, stall_prefetch}, {1'(!eng), 1'(eng)});
      repeat (8) @(negedge clk);
      cmd_valid = 1'b1; cmd_func = 3'd0; cmd_retries = '0; cmd_engine = !1'(eng);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(stall_main == !eng && stall_prefetch == 1'(eng), "R8 ignored command kept stall",
          {stall_main, stall_prefetch}, {1'(!eng), 1'(eng)});
      wait_end();
      chk(got_to && n_reads == 2, "R8 ignored command changed nothing", {got_to, 8'(n_reads)}, {1'b1, 8'd2});
      @(negedge clk);
      chk(!busy && !stall_main && !stall_prefetch && cmd_ready, "R9 idle after end",
          {busy, stall_main, stall_prefetch}, 0);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule